// File: doc/BRIEF.md
# Grouped Interrupt Level Controller

This block keeps the state of a bank of priority interrupt levels, sixteen per group. Each level is in one of four states (disarmed, armed, waiting, active) and also has an enable flag of its own. A command names one group, a three-bit function and a sixteen-bit selection mask. In one clock the block applies that function to the levels of the named group. Levels outside the group keep their state.

Each level also has a trigger input of its own, which acts like the trigger function. Every cycle the block reports the lowest-numbered level that is waiting and enabled, which is the level of highest priority. Some levels can be marked as power-fail levels through a parameter. No command can disarm or disable them. The block takes a command that has already been decoded. It does not compute addresses, vector traps or run the acknowledge sequence.

Top module: `irq_group_ctrl`

## Requirements
- R1: While reset is held, and after reset is released, every level reads disarmed with its enable flag at 0, and `irq_valid` is 0. The state encoding on `level_state` is disarmed=0, armed=1, waiting=2, active=3. Level n uses bits [2n+1:2n].
- R2: Group g covers levels 16g to 16g+15. `cmd_mask[15-i]` selects level i of the group, so the MSB of the mask selects the highest-priority level of the group.
- R3: Function 0 (set active) moves each selected level that is armed or waiting to active. A selected level in any other state is unchanged.
- R4: Function 1 (disarm) puts each selected level in the disarmed state. This also removes the level from the waiting or active state.
- R5: Function 2 (arm and enable) and function 3 (arm and disable) put each selected level in the armed state, whatever its state was. This clears waiting or active. The enable flag is set to 1 by function 2 and to 0 by function 3.
- R6: Function 4 sets the enable flag of each selected level and function 5 clears it. Neither function changes the state.
- R7: Function 6 sets the enable flag of each selected level and clears the enable flag of each unselected level in the group.
- R8: Function 7 (trigger) moves each selected armed level to waiting. Selected levels in other states are unchanged.
- R9: For every function except 6, a level whose mask bit is 0 is not changed.
- R10: When `trig_in[n]` is 1 and level n is armed, level n moves to waiting. If a command selects the same level in the same cycle, the command decides the result and the trigger has no effect.
- R11: A level whose bit in `PWR_MASK` is set is never disarmed and never disabled. Functions 1, 3, 5 and 6 leave its enable flag alone. Function 1 returns it to armed if it was armed, waiting or active.
- R12: `irq_valid` and `irq_level` report the lowest-numbered level that is waiting and enabled. They are registered, so they show the state of the levels one clock after that state changes.
- R13: A command whose group number is `NUM_GROUPS` or higher changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_group | input | 4 | Group number of the command |
| cmd_func | input | 3 | Function code |
| cmd_mask | input | 16 | Selection mask; bit 15 selects level 0 of the group |
| trig_in | input | NUM_GROUPS*16 | Trigger pulse, one bit per level |
| level_state | output | 2*NUM_GROUPS*16 | Two-bit state of each level |
| level_en | output | NUM_GROUPS*16 | Enable flag of each level |
| irq_valid | output | 1 | Some level is waiting and enabled |
| irq_level | output | clog2(NUM_GROUPS*16) | Number of the lowest such level |

## Verification
The bench aims at the corners where the functions differ in small ways:

- **Set active on a disarmed level.** A design that promoted every selected level would raise an idle level to active.
- **Trigger on a disarmed level.** A design that ignored the armed condition would make the level wait.
- **Mask-driven enable (function 6).** A design that treated it like plain enable would leave unselected levels enabled.
- **Power-fail levels.** A design without protection would show them disarmed or disabled.

Further cases:

- **Trigger against a command.** A trigger and a command hit the same level in the same cycle. A design that let the trigger win would report waiting where the command kept the level armed.
- **Priority and latency.** With two levels waiting, the output must name the lower-numbered one, and only one clock after the change.
- **Unused group number.** A command to that number must leave every level exactly as it was.

// File: rtl/irq_group_pkg.sv
package irq_group_pkg;

  localparam int unsigned GRP_SIZE = 16;

  typedef enum logic [1:0] {
    LV_IDLE   = 2'd0,
    LV_ARMED  = 2'd1,
    LV_WAIT   = 2'd2,
    LV_ACTIVE = 2'd3
  } lvl_state_e;

  typedef enum logic [2:0] {
    FN_SET_ACT  = 3'd0,
    FN_DISARM   = 3'd1,
    FN_ARM_EN   = 3'd2,
    FN_ARM_DIS  = 3'd3,
    FN_ENABLE   = 3'd4,
    FN_DISABLE  = 3'd5,
    FN_MASK_EN  = 3'd6,
    FN_TRIGGER  = 3'd7
  } lvl_func_e;

endpackage

// File: rtl/irq_level_cell.sv
module irq_level_cell
  import irq_group_pkg::*;
#(
  parameter bit PROTECT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       grp_hit,
  input  logic       sel,
  input  lvl_func_e  func,
  input  logic       trig,
  output lvl_state_e st_o,
  output logic       en_o
);

  lvl_state_e st_q, st_d;
  logic       en_q, en_d;
  logic       cmd_here;
  logic       upd;

  assign cmd_here = grp_hit && sel;
  assign upd      = grp_hit || trig;

  always_comb begin
    st_d = st_q;
    en_d = en_q;
    if (cmd_here) begin
      case (func)
        FN_SET_ACT: if (st_q == LV_ARMED || st_q == LV_WAIT) st_d = LV_ACTIVE;
        FN_DISARM:  st_d = (PROTECT && st_q != LV_IDLE) ? LV_ARMED : LV_IDLE;
        FN_ARM_EN:  begin st_d = LV_ARMED; en_d = 1'b1; end
        FN_ARM_DIS: begin st_d = LV_ARMED; if (!PROTECT) en_d = 1'b0; end
        FN_ENABLE:  en_d = 1'b1;
        FN_DISABLE: if (!PROTECT) en_d = 1'b0;
        FN_MASK_EN: en_d = 1'b1;
        FN_TRIGGER: if (st_q == LV_ARMED) st_d = LV_WAIT;
        default:    ;
      endcase
    end else if (grp_hit && func == FN_MASK_EN && !PROTECT) begin
      en_d = 1'b0;
    end
    if (trig && !cmd_here && st_q == LV_ARMED) st_d = LV_WAIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= LV_IDLE;
      en_q <= 1'b0;
    end else if (upd) begin
      st_q <= st_d;
      en_q <= en_d;
    end
  end

  assign st_o = st_q;
  assign en_o = en_q;

  // R9: with no command to the group and no trigger, the level holds
  p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!grp_hit && !trig) |=> ($stable(st_q) && $stable(en_q)));

  // R8/R10: a level only starts waiting from the armed state
  p_wait_from_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != LV_WAIT) |=> (st_q != LV_WAIT || $past(st_q) == LV_ARMED));

  // R3: a disarmed level never jumps straight to active
  p_idle_not_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LV_IDLE) |=> (st_q != LV_ACTIVE));

  generate
    if (PROTECT) begin : g_prot_chk
      // R11: protected levels stay enabled and stay armed once armed
      p_prot_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> en_q);
      p_prot_armed_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != LV_IDLE) |=> (st_q != LV_IDLE));
    end
  endgenerate

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N_REQ = 32,
  localparam int unsigned IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);

  logic             found_d, valid_q;
  logic [IDX_W-1:0] idx_d, idx_q;

  always_comb begin
    found_d = 1'b0;
    idx_d   = '0;
    for (int i = N_REQ - 1; i >= 0; i--) begin
      if (req[i]) begin
        found_d = 1'b1;
        idx_d   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      valid_q <= found_d;
      idx_q   <= idx_d;
    end
  end

  assign valid_o = valid_q;
  assign idx_o   = idx_q;

  // R12: a reported level was requesting on the previous cycle
  p_irq_backed_r12: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ($past(req) != '0));

endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
  import irq_group_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 2,
  parameter logic [15:0] PWR_MASK   = 16'h0003,
  localparam int unsigned NLEV  = NUM_GROUPS * GRP_SIZE,
  localparam int unsigned LVL_W = (NLEV > 1) ? $clog2(NLEV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_group,
  input  logic [2:0]        cmd_func,
  input  logic [15:0]       cmd_mask,
  input  logic [NLEV-1:0]   trig_in,
  output logic [2*NLEV-1:0] level_state,
  output logic [NLEV-1:0]   level_en,
  output logic              irq_valid,
  output logic [LVL_W-1:0]  irq_level
);

  logic [1:0]      rst_sync_q;
  logic            rst_i;
  lvl_func_e       func;
  lvl_state_e      st   [NLEV];
  logic [NLEV-1:0] en;
  logic [NLEV-1:0] ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  assign func = lvl_func_e'(cmd_func);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic hit;
    assign hit = cmd_valid && (cmd_group == 4'(g));
    for (genvar i = 0; i < GRP_SIZE; i++) begin : g_lvl
      localparam int unsigned L = g * GRP_SIZE + i;
      irq_level_cell #(
        .PROTECT ((g == 0) ? PWR_MASK[i] : 1'b0)
      ) u_cell (
        .clk     (clk),
        .rst_n   (rst_i),
        .grp_hit (hit),
        .sel     (cmd_mask[GRP_SIZE-1-i]),
        .func    (func),
        .trig    (trig_in[L]),
        .st_o    (st[L]),
        .en_o    (en[L])
      );
      assign level_state[2*L +: 2] = st[L];
      assign ready[L] = (st[L] == LV_WAIT) && en[L];
    end
  end

  assign level_en = en;

  irq_prio_pick #(.N_REQ(NLEV)) u_pick (
    .clk     (clk),
    .rst_n   (rst_i),
    .req     (ready),
    .valid_o (irq_valid),
    .idx_o   (irq_level)
  );

  // R13: a command to a group number that is not built changes nothing
  p_bad_group_r13: assert property (@(posedge clk) disable iff (!rst_i)
    (cmd_valid && int'(cmd_group) >= NUM_GROUPS && trig_in == '0)
      |=> ($stable(level_state) && $stable(level_en)));

endmodule

// File: tb/irq_group_ctrl_test.sv
module irq_group_ctrl_test;

  localparam int NG = 2;
  localparam int NL = NG * 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cmd_valid;
  logic [3:0]      cmd_group;
  logic [2:0]      cmd_func;
  logic [15:0]     cmd_mask;
  logic [NL-1:0]   trig_in;
  logic [2*NL-1:0] level_state;
  logic [NL-1:0]   level_en;
  logic            irq_valid;
  logic [4:0]      irq_level;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  irq_group_ctrl #(.NUM_GROUPS(NG), .PWR_MASK(16'h0003)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_group(cmd_group),
    .cmd_func(cmd_func), .cmd_mask(cmd_mask), .trig_in(trig_in),
    .level_state(level_state), .level_en(level_en),
    .irq_valid(irq_valid), .irq_level(irq_level)
  );

  localparam int IDLE = 0, ARMED = 1, WAITS = 2, ACT = 3;

  function automatic logic [15:0] m(input int i);
    return 16'h8000 >> i;
  endfunction

  function automatic int st(input int l);
    return int'(level_state[2*l +: 2]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmd(input int g, input int f, input logic [15:0] msk,
                     input logic [NL-1:0] trg = '0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_group = 4'(g); cmd_func = 3'(f);
    cmd_mask = msk; trig_in = trg;
    @(negedge clk);
    cmd_valid = 1'b0; trig_in = '0;
  endtask

  task automatic pulse(input int l);
    @(negedge clk);
    trig_in = '0; trig_in[l] = 1'b1;
    @(negedge clk);
    trig_in = '0;
  endtask

  task automatic t_reset();
    int nz = 0;
    for (int l = 0; l < NL; l++) if (st(l) != IDLE || level_en[l]) nz++;
    chk("R1 levels not idle after reset", nz, 0);
    chk("R1 irq_valid after reset", int'(irq_valid), 0);
  endtask

  task automatic t_arm();
    cmd(0, 2, m(2) | m(3));
    chk("R5 lvl2 armed", st(2), ARMED);
    chk("R5 lvl3 en", int'(level_en[3]), 1);
    chk("R2 R9 lvl4 untouched", st(4), IDLE);
  endtask

  task automatic t_trig_cmd();
    cmd(0, 7, m(3) | m(5));
    chk("R8 lvl3 waiting", st(3), WAITS);
    chk("R8 lvl5 idle ignored", st(5), IDLE);
    chk("R12 irq not yet valid", int'(irq_valid), 0);
    @(negedge clk);
    chk("R12 irq valid", int'(irq_valid), 1);
    chk("R12 irq level", int'(irq_level), 3);
  endtask

  task automatic t_ext_trig();
    logic [NL-1:0] tr;
    cmd(1, 3, m(4) | m(5));
    chk("R5 lvl20 disabled", int'(level_en[20]), 0);
    pulse(20);
    chk("R10 lvl20 waiting", st(20), WAITS);
    cmd(1, 4, m(4));
    chk("R6 lvl20 enabled", int'(level_en[20]), 1);
    chk("R6 lvl20 state kept", st(20), WAITS);
    @(negedge clk);
    chk("R12 lower level wins", int'(irq_level), 3);
    tr = '0; tr[21] = 1'b1;
    cmd(1, 4, m(5), tr);
    chk("R10 command beats trigger", st(21), ARMED);
  endtask

  task automatic t_set_active();
    cmd(0, 0, m(2) | m(3) | m(4));
    chk("R3 armed to active", st(2), ACT);
    chk("R3 waiting to active", st(3), ACT);
    chk("R3 idle unchanged", st(4), IDLE);
    @(negedge clk);
    chk("R12 next level", int'(irq_level), 20);
  endtask

  task automatic t_disarm_arm();
    cmd(0, 1, m(2));
    chk("R4 active to idle", st(2), IDLE);
    cmd(0, 3, m(3));
    chk("R5 active to armed", st(3), ARMED);
    chk("R5 arm-disable en", int'(level_en[3]), 0);
  endtask

  task automatic t_mask_en();
    cmd(1, 6, m(5));
    chk("R7 selected enabled", int'(level_en[21]), 1);
    chk("R7 unselected disabled", int'(level_en[20]), 0);
    @(negedge clk);
    chk("R12 nothing ready", int'(irq_valid), 0);
  endtask

  task automatic t_protect();
    cmd(0, 2, m(0) | m(1));
    cmd(0, 1, m(0));
    chk("R11 lvl0 not disarmed", st(0), ARMED);
    cmd(0, 5, m(1));
    chk("R11 lvl1 not disabled", int'(level_en[1]), 1);
    cmd(0, 6, 16'h0000);
    chk("R11 lvl0 en kept", int'(level_en[0]), 1);
    pulse(0);
    @(negedge clk);
    chk("R12 lvl0 reported", int'(irq_level), 0);
    chk("R12 lvl0 valid", int'(irq_valid), 1);
  endtask

  task automatic t_bad_group();
    logic [2*NL-1:0] s0 = level_state;
    logic [NL-1:0]   e0 = level_en;
    cmd(5, 2, 16'hFFFF);
    chk("R13 state unchanged", int'(level_state == s0), 1);
    chk("R13 enable unchanged", int'(level_en == e0), 1);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_group = '0; cmd_func = '0;
    cmd_mask = '0; trig_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_arm();
    t_trig_cmd();
    t_ext_trig();
    t_set_active();
    t_disarm_arm();
    t_mask_en();
    t_protect();
    t_bad_group();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule